// File: doc/BRIEF.md
# ADC Result Register Bank with Read-Clear Status Flags

This block holds the most recent 10-bit analog-to-digital conversion result for each of several channels and presents them to a processor as read-only byte registers. A converter sequencer delivers results through a one-cycle strobe that carries a channel index and the 10-bit value. The processor reads through a byte-wide port made of an address, a read strobe and read data.

Each channel owns two bytes. The upper byte carries the top eight result bits. The lower byte carries the two least significant result bits, a field of constant ones, and two status bits. One status bit says that a fresh result is waiting. The other says that a result was replaced before the processor had read both bytes of it. Both status bits clear as a side effect of reading the lower byte. The read data is combinational from the address. Flag and read-tracking updates take effect at the clock edge where the read strobe is high.

Top module: `adc_result_bank`

## Requirements
- R1: The upper byte of channel n (byte address 2n+1) reads result bits 9..2. Bits 7..6 of the lower byte (byte address 2n) read result bits 1..0.
- R2: Bits 5..2 of every lower byte always read as 1.
- R3: Bit 0 of the lower byte (the ready flag) becomes 1 in the cycle after a result is written to that channel.
- R4: A lower-byte read strobe, with no write to the same channel in that cycle, clears the ready flag at that clock edge.
- R5: Bit 1 of the lower byte (the overrun flag) becomes 1 when a result is written to a channel whose previous result has not had both its upper and its lower byte read since it was written. It stays 1 until it is cleared. The first write after reset never raises it.
- R6: A lower-byte read returns the current overrun value. With no write to the same channel in that cycle, the read then clears the flag.
- R7: After reset every flag is 0 and every result is 0, so a lower byte reads 0x3C and an upper byte reads 0x00.
- R8: When a read and a write hit the same channel in one cycle, the read returns the old contents. The write wins: it sets the ready flag and keeps or raises overrun. Its overrun test uses the read status from before that cycle.
- R9: Byte addresses at or above twice the channel count read 0. Strobes to them change no state.
- R10: A read with the strobe low, and an upper-byte read, leave both flags unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_valid | input | 1 | Conversion-complete strobe |
| wr_chan | input | CH_W | Channel index of the result |
| wr_data | input | RES_W | Conversion result |
| rd_en | input | 1 | Processor read strobe |
| rd_addr | input | ADDR_W | Processor byte address |
| rd_data | output | 8 | Read data for rd_addr |

## Verification
The hardest situation to reach is a write and a lower-byte read landing on the same channel in the same cycle while that channel's previous result is only half read. Here the read must see the old flags, the read-clear must lose to the write, and the overrun test must use the read status from before that cycle. Directed sequences build this state on purpose: a write, then an upper-only read, then a simultaneous lower read and write. A long random run on a small channel count, with reads and writes frequent enough to collide, checks every byte against a reference model kept in the bench.

// File: rtl/adc_bank_pkg.sv
package adc_bank_pkg;
    localparam int BYTE_W = 8;

    // Lower byte layout: low result bits on top, ones padding, overrun, ready.
    function automatic logic [BYTE_W-1:0] fmt_low(input logic [1:0] lsbs,
                                                  input logic ovr,
                                                  input logic rdy);
        return {lsbs, 4'hF, ovr, rdy};
    endfunction
endpackage

// File: rtl/adc_addr_decode.sv
module adc_addr_decode #(
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 4,
    parameter int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic              wr_valid,
    input  logic [CH_W-1:0]   wr_chan,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [NUM_CH-1:0] wr_vec,
    output logic [NUM_CH-1:0] rd_lo_vec,
    output logic [NUM_CH-1:0] rd_hi_vec,
    output logic              sel_hit,
    output logic              sel_upper,
    output logic [CH_W-1:0]   sel_chan
);
    logic [ADDR_W-2:0] slot;

    assign slot      = rd_addr[ADDR_W-1:1];
    assign sel_hit   = (32'(slot) < NUM_CH);
    assign sel_upper = rd_addr[0];
    assign sel_chan  = slot[CH_W-1:0];

    always_comb begin
        wr_vec    = '0;
        rd_lo_vec = '0;
        rd_hi_vec = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            wr_vec[i]    = wr_valid && (32'(wr_chan) == i);
            rd_lo_vec[i] = rd_en && sel_hit && !sel_upper && (32'(slot) == i);
            rd_hi_vec[i] = rd_en && sel_hit &&  sel_upper && (32'(slot) == i);
        end
    end
endmodule

// File: rtl/adc_chan_slot.sv
module adc_chan_slot #(
    parameter int RES_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_hit,
    input  logic [RES_W-1:0] wr_data,
    input  logic             rd_lo,
    input  logic             rd_hi,
    output logic [RES_W-1:0] data_q,
    output logic             rdy_q,
    output logic             ovr_q
);
    typedef struct packed {
        logic [RES_W-1:0] data;
        logic             rdy;
        logic             ovr;
        logic             hi_seen;
        logic             lo_seen;
    } slot_t;

    slot_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (wr_hit) begin
            s_d.data    = wr_data;
            s_d.rdy     = 1'b1;
            s_d.ovr     = s_q.ovr | ~(s_q.hi_seen & s_q.lo_seen);
            s_d.hi_seen = 1'b0;
            s_d.lo_seen = 1'b0;
        end else begin
            if (rd_lo) begin
                s_d.rdy     = 1'b0;
                s_d.ovr     = 1'b0;
                s_d.lo_seen = 1'b1;
            end
            if (rd_hi) begin
                s_d.hi_seen = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.data    <= '0;
            s_q.rdy     <= 1'b0;
            s_q.ovr     <= 1'b0;
            s_q.hi_seen <= 1'b1;
            s_q.lo_seen <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign data_q = s_q.data;
    assign rdy_q  = s_q.rdy;
    assign ovr_q  = s_q.ovr;

    assert_rdy_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hit |=> rdy_q);
    assert_rdy_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_lo && !wr_hit) |=> !rdy_q);
    assert_ovr_raise_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && !(s_q.hi_seen && s_q.lo_seen)) |=> ovr_q);
    assert_ovr_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && ovr_q) |=> ovr_q);
    assert_ovr_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_lo && !wr_hit) |=> !ovr_q);
    assert_flags_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_hit && !rd_lo) |=> ($stable(rdy_q) && $stable(ovr_q)));
    assert_data_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hit |=> (data_q == $past(wr_data)));
    assert_data_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_hit |=> $stable(data_q));
endmodule

// File: rtl/adc_read_mux.sv
module adc_read_mux
    import adc_bank_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int RES_W  = 10,
    parameter int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic [NUM_CH-1:0][RES_W-1:0] data_all,
    input  logic [NUM_CH-1:0]            rdy_all,
    input  logic [NUM_CH-1:0]            ovr_all,
    input  logic                         sel_hit,
    input  logic                         sel_upper,
    input  logic [CH_W-1:0]              sel_chan,
    output logic [BYTE_W-1:0]            rd_data
);
    logic [RES_W-1:0] cur;

    assign cur = data_all[sel_chan];

    always_comb begin
        rd_data = '0;
        if (sel_hit) begin
            if (sel_upper) rd_data = cur[RES_W-1:RES_W-BYTE_W];
            else           rd_data = fmt_low(cur[1:0], ovr_all[sel_chan], rdy_all[sel_chan]);
        end
    end
endmodule

// File: rtl/adc_result_bank.sv
module adc_result_bank
    import adc_bank_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int RES_W  = 10,
    parameter int ADDR_W = 4,
    parameter int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [CH_W-1:0]   wr_chan,
    input  logic [RES_W-1:0]  wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data
);
    localparam int MAP_BYTES = 2 * NUM_CH;

    logic [NUM_CH-1:0]            wr_vec, rd_lo_vec, rd_hi_vec;
    logic [NUM_CH-1:0][RES_W-1:0] data_all;
    logic [NUM_CH-1:0]            rdy_all, ovr_all;
    logic                         sel_hit, sel_upper;
    logic [CH_W-1:0]              sel_chan;

    adc_addr_decode #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .CH_W(CH_W)) u_dec (
        .wr_valid(wr_valid), .wr_chan(wr_chan), .rd_en(rd_en), .rd_addr(rd_addr),
        .wr_vec(wr_vec), .rd_lo_vec(rd_lo_vec), .rd_hi_vec(rd_hi_vec),
        .sel_hit(sel_hit), .sel_upper(sel_upper), .sel_chan(sel_chan)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_slot
        adc_chan_slot #(.RES_W(RES_W)) u_slot (
            .clk(clk), .rst_n(rst_n),
            .wr_hit(wr_vec[g]), .wr_data(wr_data),
            .rd_lo(rd_lo_vec[g]), .rd_hi(rd_hi_vec[g]),
            .data_q(data_all[g]), .rdy_q(rdy_all[g]), .ovr_q(ovr_all[g])
        );
    end

    adc_read_mux #(.NUM_CH(NUM_CH), .RES_W(RES_W), .CH_W(CH_W)) u_mux (
        .data_all(data_all), .rdy_all(rdy_all), .ovr_all(ovr_all),
        .sel_hit(sel_hit), .sel_upper(sel_upper), .sel_chan(sel_chan),
        .rd_data(rd_data)
    );

    assert_pad_ones_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_addr[0] && (32'(rd_addr) < MAP_BYTES)) |-> (rd_data[5:2] == 4'hF));
    assert_unmapped_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(rd_addr) >= MAP_BYTES) |-> (rd_data == 8'h00));
    assert_one_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_vec));
endmodule

// File: tb/adc_result_bank_test.sv
module adc_result_bank_test;
    localparam int NCH = 4;
    localparam int AW  = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_valid = 1'b0;
    logic [1:0] wr_chan = '0;
    logic [9:0] wr_data = '0;
    logic       rd_en = 1'b0;
    logic [3:0] rd_addr = '0;
    logic [7:0] rd_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [9:0] m_data [NCH];
    logic       m_rdy  [NCH];
    logic       m_ovr  [NCH];
    logic       m_hi   [NCH];
    logic       m_lo   [NCH];

    always #2 clk = ~clk;

    adc_result_bank #(.NUM_CH(NCH), .RES_W(10), .ADDR_W(AW)) uut (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_chan(wr_chan),
        .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    function automatic logic [7:0] exp_byte(input logic [3:0] a);
        int c = int'(a) / 2;
        if (c >= NCH) return 8'h00;
        if (a[0]) return m_data[c][9:2];
        return {m_data[c][1:0], 4'hF, m_ovr[c], m_rdy[c]};
    endfunction

    function automatic string tag_of(input logic [3:0] a);
        if (int'(a) >= 2 * NCH) return "R9";
        if (a[0]) return "R1";
        return "R6";
    endfunction

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: addr %0d got %02h expected %02h", tag, rd_addr, got, exp);
        end
    endtask

    task automatic model_reset();
        for (int c = 0; c < NCH; c++) begin
            m_data[c] = '0; m_rdy[c] = 0; m_ovr[c] = 0; m_hi[c] = 1; m_lo[c] = 1;
        end
    endtask

    task automatic model_edge(input logic wv, input logic [1:0] wc, input logic [9:0] wd,
                              input logic re, input logic [3:0] ra);
        for (int c = 0; c < NCH; c++) begin
            logic w, rl, rh;
            w  = wv && (int'(wc) == c);
            rl = re && (int'(ra) == 2 * c);
            rh = re && (int'(ra) == 2 * c + 1);
            if (w) begin
                m_data[c] = wd; m_rdy[c] = 1;
                m_ovr[c] = m_ovr[c] | ~(m_hi[c] & m_lo[c]);
                m_hi[c] = 0; m_lo[c] = 0;
            end else begin
                if (rl) begin m_rdy[c] = 0; m_ovr[c] = 0; m_lo[c] = 1; end
                if (rh) m_hi[c] = 1;
            end
        end
    endtask

    // One cycle: drive, check combinational read data, then advance the model.
    task automatic step(input string tag, input logic wv, input logic [1:0] wc,
                        input logic [9:0] wd, input logic re, input logic [3:0] ra);
        @(negedge clk);
        wr_valid = wv; wr_chan = wc; wr_data = wd; rd_en = re; rd_addr = ra;
        #1;
        check(tag, rd_data, exp_byte(ra));
        @(posedge clk);
        model_edge(wv, wc, wd, re, ra);
    endtask

    task automatic peek(input string tag, input logic [3:0] ra);
        step(tag, 1'b0, 2'd0, 10'd0, 1'b0, ra);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R7: reset contents on every byte
        for (int a = 0; a < 2 * NCH; a++) begin
            @(negedge clk); rd_addr = 4'(a); #1;
            check("R7", rd_data, (a % 2) ? 8'h00 : 8'h3C);
        end

        // R5: first write after reset raises no overrun; R3 ready set
        step("R3", 1, 2'd0, 10'h2B5, 0, 4'd0);
        peek("R3", 4'd0);
        peek("R1", 4'd1);
        // R5: second write with nothing read raises overrun
        step("R5", 1, 2'd0, 10'h1C6, 0, 4'd0);
        // R10: strobe-low reads and an upper read leave flags set
        peek("R10", 4'd0);
        step("R10", 0, 2'd0, 10'd0, 1, 4'd1);
        peek("R10", 4'd0);
        // R6: lower read returns overrun=1 then clears it (R4 ready too)
        step("R6", 0, 2'd0, 10'd0, 1, 4'd0);
        peek("R4", 4'd0);
        // R5: both halves read, so next write leaves overrun clear
        step("R5", 1, 2'd0, 10'h0F3, 0, 4'd0);
        peek("R5", 4'd0);
        // R8: upper read only, then lower read collides with a write
        step("R8", 0, 2'd0, 10'd0, 1, 4'd1);
        step("R8", 1, 2'd0, 10'h3FF, 1, 4'd0);
        peek("R8", 4'd0);
        peek("R8", 4'd1);
        // R9: unmapped addresses read 0 and strobes there change nothing
        step("R9", 0, 2'd0, 10'd0, 1, 4'd8);
        step("R9", 0, 2'd0, 10'd0, 1, 4'd15);
        peek("R9", 4'd0);
        // R2: padding ones visible on a channel holding an all-zero result
        step("R2", 1, 2'd3, 10'h000, 0, 4'd6);
        peek("R2", 4'd6);

        // Random mix with frequent collisions
        for (int i = 0; i < 4000; i++) begin
            logic wv, re;
            logic [3:0] ra;
            wv = ($urandom % 3) == 0;
            re = ($urandom % 4) != 0;
            ra = 4'($urandom % 10);
            step(tag_of(ra), wv, 2'($urandom % NCH), 10'($urandom), re, ra);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule